// File: doc/BRIEF.md
# Serial Management Register Slave

This block is the management end of one PHY port. A station manager clocks frames in over a two-wire serial bus: a clock `mdc` and a bidirectional data line, split here into `mdio_in`, `mdio_out` and `mdio_oe`. The block samples `mdc` and `mdio_in` into the fast system clock domain and decodes read and write frames. It serves a small register file made of three parts. The control word at address 0 is writable. Addresses 1 to 6 return fixed status defaults. Addresses 16 to 31 are writable vendor registers.

Two of these registers drive the datapath. Bit 10 of the control word asks for isolation. The low five bits of vendor register 25 hold the port's own bus address. Both reset to values taken from the strapped address pins and the port index. The block outputs `isolate_o` as the OR of the isolate bit and an all-zero address. Management frames are still answered while the port is isolated.

Frame decoding follows a named state machine:
- **S_PREAMBLE** counts consecutive 1 bits.
- A 0 that arrives after at least 32 ones moves to **S_START**. Any other 0 clears the count.
- **S_START** needs a 1 to go on to **S_OPCODE**.
- **S_OPCODE** accepts 10 (read) or 01 (write) and moves to **S_PHYAD**. Any other code returns to S_PREAMBLE.
- **S_PHYAD** collects the five address bits, then **S_REGAD** collects the five register bits.
- If the address does not match, S_REGAD returns to S_PREAMBLE.
- A matching read passes through **S_TA_REL** (line released), then **S_TA_DRV** (drives 0), then **S_RD_DATA** (16 bits) and back to S_PREAMBLE.
- A matching write passes through **S_TA_WR** (two bits), then **S_WR_DATA** (16 bits), commits on the last bit and returns to S_PREAMBLE.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is at least 32 ones, then start 01, opcode (10 read, 01 write), 5-bit bus address and 5-bit register address, all MSB first. On a matching read the slave leaves `mdio_oe` low for the first turnaround bit. It drives 0 on the second turnaround bit, then drives the 16 register bits MSB first, each bit valid before the `mdc` rising edge that samples it.
- R2: A matching write to register 0 stores all 16 bits, and `ctrl_o` shows the stored value.
- R3: `isolate_o` is 1 whenever `ctrl_o[10]` is 1.
- R4: Register 25 bits 4:0 are the bus address, are writable and appear on `phy_addr_o`. Later frames must carry the new address. After reset they equal the effective strap.
- R5: When `phy_addr_o` is 0, `isolate_o` is 1. Writing 0 to the address field leaves `ctrl_o[10]` unchanged.
- R6: After reset, `ctrl_o` is 0x0400 if the effective strap is 00000, and 0x0000 otherwise.
- R7: The effective strap is `strap_addr` with bit 0 forced to 1 when `port_sel` is 1.
- R8: A frame whose bus address differs from `phy_addr_o` changes no register and never raises `mdio_oe`.
- R9: Registers 1 to 6 read 0x7809, 0x0043, 0x7410, 0x01E1, 0x0000 and 0x0004, and ignore writes. Registers 7 to 15 read 0 and ignore writes.
- R10: Registers 16 to 31 are 16-bit read/write storage.
- R11: A frame with fewer than 32 preamble ones, or with opcode 00 or 11, is ignored.
- R12: Reads and writes are served normally while `isolate_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than mdc |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc | input | 1 | Management clock; bits are sampled on its rising edge |
| mdio_in | input | 1 | Management data line as seen by the slave |
| strap_addr | input | 5 | Strapped bus address |
| port_sel | input | 1 | Port index; 1 forces address bit 0 high |
| mdio_out | output | 1 | Data driven by the slave |
| mdio_oe | output | 1 | Drive enable for mdio_out |
| isolate_o | output | 1 | Isolation request to the datapath |
| ctrl_o | output | 16 | Current control register |
| phy_addr_o | output | 5 | Current bus address field |

## Verification
The bound checker enforces these rules on every cycle:
- the isolate output follows both of its causes;
- the control word and address field change only on a write strobe aimed at them;
- the first bit the slave drives after enabling its output is 0.

Only the bench scenarios can show frame-level behaviour: the release-then-zero turnaround, read data order, reset values under different straps and port indices, rejection of foreign addresses, short preambles and bad opcodes, read-only and absent registers, and re-addressing through register 25.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 5;

    typedef enum logic [3:0] {
        S_PREAMBLE,
        S_START,
        S_OPCODE,
        S_PHYAD,
        S_REGAD,
        S_TA_REL,
        S_TA_DRV,
        S_RD_DATA,
        S_TA_WR,
        S_WR_DATA
    } mdio_state_e;

    // fixed contents of the read-only standard registers 1..6
    function automatic logic [DATA_W-1:0] std_default(input logic [2:0] idx);
        logic [DATA_W-1:0] v;
        case (idx)
            3'd1:    v = 16'h7809;
            3'd2:    v = 16'h0043;
            3'd3:    v = 16'h7410;
            3'd4:    v = 16'h01E1;
            3'd5:    v = 16'h0000;
            3'd6:    v = 16'h0004;
            default: v = 16'h0000;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc,
    input  logic mdio_in,
    output logic tick,
    output logic bit_o
);
    logic [STAGES-1:0] mdc_sh;
    logic [STAGES-1:0] dat_sh;
    logic              mdc_last;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mdc_sh <= '0;
                    dat_sh <= '1;
                end else begin
                    mdc_sh <= mdc;
                    dat_sh <= mdio_in;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mdc_sh <= '0;
                    dat_sh <= '1;
                end else begin
                    mdc_sh <= {mdc_sh[STAGES-2:0], mdc};
                    dat_sh <= {dat_sh[STAGES-2:0], mdio_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mdc_last <= 1'b0;
        else        mdc_last <= mdc_sh[STAGES-1];
    end

    assign tick  = mdc_sh[STAGES-1] & ~mdc_last;
    assign bit_o = dat_sh[STAGES-1];

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bit_in,
    input  logic [ADDR_W-1:0] my_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              mdio_out,
    output logic              mdio_oe
);
    localparam int PCW = $clog2(PRE_LEN + 1);
    localparam logic [PCW-1:0] PRE_FULL = PCW'(PRE_LEN);

    mdio_state_e        state, nxt;
    logic [DATA_W-2:0]  sh;
    logic [3:0]         cnt;
    logic [PCW-1:0]     pre_cnt;
    logic               is_rd;
    logic [ADDR_W-1:0]  phy_q;
    logic [ADDR_W-1:0]  reg_q;
    logic [DATA_W-1:0]  rd_sh;
    logic [1:0]         op_now;

    assign op_now  = {sh[0], bit_in};
    assign rd_addr = {sh[3:0], bit_in};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_PREAMBLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (tick) begin
            unique case (state)
                S_PREAMBLE: if (!bit_in && pre_cnt == PRE_FULL) nxt = S_START;
                S_START:    nxt = bit_in ? S_OPCODE : S_PREAMBLE;
                S_OPCODE:   if (cnt == 4'd1)
                                nxt = (op_now == 2'b10 || op_now == 2'b01) ? S_PHYAD : S_PREAMBLE;
                S_PHYAD:    if (cnt == 4'd4) nxt = S_REGAD;
                S_REGAD:    if (cnt == 4'd4) begin
                                if (phy_q != my_addr) nxt = S_PREAMBLE;
                                else                  nxt = is_rd ? S_TA_REL : S_TA_WR;
                            end
                S_TA_REL:   nxt = S_TA_DRV;
                S_TA_DRV:   nxt = S_RD_DATA;
                S_RD_DATA:  if (cnt == 4'd15) nxt = S_PREAMBLE;
                S_TA_WR:    if (cnt == 4'd1) nxt = S_WR_DATA;
                S_WR_DATA:  if (cnt == 4'd15) nxt = S_PREAMBLE;
                default:    nxt = S_PREAMBLE;
            endcase
        end
    end

    // field capture datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh      <= '0;
            cnt     <= '0;
            pre_cnt <= '0;
            is_rd   <= 1'b0;
            phy_q   <= '0;
            reg_q   <= '0;
            rd_sh   <= '0;
        end else if (tick) begin
            sh <= {sh[DATA_W-3:0], bit_in};
            if (state != S_PREAMBLE) pre_cnt <= '0;
            unique case (state)
                S_PREAMBLE: begin
                    cnt <= '0;
                    if (!bit_in)                 pre_cnt <= '0;
                    else if (pre_cnt != PRE_FULL) pre_cnt <= pre_cnt + 1'b1;
                end
                S_START:  cnt <= '0;
                S_OPCODE: begin
                    if (cnt == 4'd1) begin
                        is_rd <= (op_now == 2'b10);
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                S_PHYAD: begin
                    if (cnt == 4'd4) begin
                        phy_q <= rd_addr;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                S_REGAD: begin
                    if (cnt == 4'd4) begin
                        reg_q <= rd_addr;
                        rd_sh <= rd_data;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                S_TA_REL, S_TA_DRV: cnt <= '0;
                S_RD_DATA: begin
                    rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
                    cnt   <= (cnt == 4'd15) ? '0 : cnt + 1'b1;
                end
                S_TA_WR:   cnt <= (cnt == 4'd1) ? '0 : cnt + 1'b1;
                S_WR_DATA: cnt <= (cnt == 4'd15) ? '0 : cnt + 1'b1;
                default:   cnt <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        mdio_oe  = (state == S_TA_DRV) || (state == S_RD_DATA);
        mdio_out = (state == S_RD_DATA) ? rd_sh[DATA_W-1] : 1'b0;
        wr_en    = tick && (state == S_WR_DATA) && (cnt == 4'd15);
        wr_addr  = reg_q;
        wr_data  = {sh, bit_in};
    end

endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
    import mdio_mgmt_pkg::*;
#(
    parameter int ADDR_REG = 25,
    parameter int ISO_BIT  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [ADDR_W-1:0] phy_addr
);
    localparam int VBASE = 16;
    localparam int NVEND = 16;
    localparam int VIDX  = ADDR_REG - VBASE;

    logic [DATA_W-1:0] vreg [NVEND];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= (eff_addr == '0) ? (DATA_W'(1) << ISO_BIT) : '0;
        end else if (wr_en && wr_addr == '0) begin
            ctrl_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NVEND; i++)
                vreg[i] <= (i == VIDX) ? DATA_W'(eff_addr) : '0;
        end else if (wr_en && wr_addr[ADDR_W-1]) begin
            vreg[wr_addr[3:0]] <= wr_data;
        end
    end

    always_comb begin
        if (rd_addr == '0)                   rd_data = ctrl_q;
        else if (rd_addr[ADDR_W-1])          rd_data = vreg[rd_addr[3:0]];
        else if (rd_addr[ADDR_W-2:3] == '0)  rd_data = std_default(rd_addr[2:0]);
        else                                 rd_data = '0;
    end

    assign phy_addr = vreg[VIDX][ADDR_W-1:0];

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_LEN     = 32,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_REG    = 25,
    parameter int ISO_BIT     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdc,
    input  logic              mdio_in,
    input  logic [4:0]        strap_addr,
    input  logic              port_sel,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              isolate_o,
    output logic [15:0]       ctrl_o,
    output logic [4:0]        phy_addr_o
);
    logic              tick;
    logic              bit_s;
    logic [ADDR_W-1:0] eff_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    assign eff_addr = {strap_addr[4:1], strap_addr[0] | port_sel};

    mdio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .mdc     (mdc),
        .mdio_in (mdio_in),
        .tick    (tick),
        .bit_o   (bit_s)
    );

    mdio_frame_fsm #(.PRE_LEN(PRE_LEN)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .bit_in   (bit_s),
        .my_addr  (phy_addr_o),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe)
    );

    mdio_reg_bank #(.ADDR_REG(ADDR_REG), .ISO_BIT(ISO_BIT)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .eff_addr (eff_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .ctrl_q   (ctrl_o),
        .phy_addr (phy_addr_o)
    );

    assign isolate_o = ctrl_o[ISO_BIT] | (phy_addr_o == '0);

endmodule

module mdio_mgmt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        mdio_out,
    input logic        mdio_oe,
    input logic        isolate_o,
    input logic [15:0] ctrl_o,
    input logic [4:0]  phy_addr_o,
    input logic        wr_en,
    input logic [4:0]  wr_addr
);
    AST_ISO_FROM_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o[10] |-> isolate_o); // R3

    AST_ISO_FROM_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_addr_o == 5'd0) |-> isolate_o); // R5

    AST_TA_FIRST_DRIVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_out); // R1

    AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == 5'd0) |=> $stable(ctrl_o)); // R2

    AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == 5'd25) |=> $stable(phy_addr_o)); // R4

endmodule

bind mdio_mgmt_slave mdio_mgmt_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mdio_out   (mdio_out),
    .mdio_oe    (mdio_oe),
    .isolate_o  (isolate_o),
    .ctrl_o     (ctrl_o),
    .phy_addr_o (phy_addr_o),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr)
);

// File: tb/mdio_mgmt_slave_test.sv
module mdio_mgmt_slave_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdc = 1'b0;
    logic        mdio_in = 1'b1;
    logic [4:0]  strap_addr = 5'd5;
    logic        port_sel = 1'b0;
    logic        mdio_out, mdio_oe, isolate_o;
    logic [15:0] ctrl_o;
    logic [4:0]  phy_addr_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    mdio_mgmt_slave uut (
        .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_in(mdio_in),
        .strap_addr(strap_addr), .port_sel(port_sel),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .isolate_o(isolate_o),
        .ctrl_o(ctrl_o), .phy_addr_o(phy_addr_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [4:0] strap, input logic psel);
        @(negedge clk);
        rst_n = 1'b0; mdc = 1'b0; mdio_in = 1'b1;
        strap_addr = strap; port_sel = psel;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // one management frame; master drives on mdc low, slave sampled just before mdc rises
    task automatic frame(input int pre, input logic [1:0] op, input logic [4:0] phy,
                         input logic [4:0] ra, input logic [15:0] wd,
                         output logic [15:0] rd, output logic ta_ok, output logic oe_seen);
        logic [31:0] f;
        f = {2'b01, op, phy, ra, 2'b10, wd};
        rd = '0; ta_ok = 1'b1; oe_seen = 1'b0;
        for (int j = 0; j < pre + 32; j++) begin
            @(negedge clk);
            mdc = 1'b0;
            if (j < pre)                         mdio_in = 1'b1;
            else if (op == 2'b10 && j - pre >= 14) mdio_in = 1'b1;
            else                                 mdio_in = f[31 - (j - pre)];
            repeat (4) @(negedge clk);
            if (mdio_oe) oe_seen = 1'b1;
            if (j - pre == 14 && mdio_oe)                ta_ok = 1'b0;
            if (j - pre == 15 && !(mdio_oe && !mdio_out)) ta_ok = 1'b0;
            if (j - pre >= 16) rd = {rd[14:0], mdio_oe ? mdio_out : 1'bx};
            mdc = 1'b1;
            repeat (4) @(negedge clk);
        end
        @(negedge clk);
        mdc = 1'b0; mdio_in = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
        logic [15:0] r; logic t, o;
        frame(32, 2'b01, phy, ra, d, r, t, o);
    endtask

    task automatic rdreg(input logic [4:0] phy, input logic [4:0] ra, output logic [15:0] d);
        logic t, o;
        frame(32, 2'b10, phy, ra, 16'h0, d, t, o);
    endtask

    task automatic t_reset_values;
        logic [15:0] d;
        do_reset(5'd5, 1'b0);
        chk("R6 ctrl after reset, strap 5", ctrl_o, 16'h0000);
        chk("R4 addr after reset", {11'b0, phy_addr_o}, 16'd5);
        chk("R3 isolate clear", {15'b0, isolate_o}, 16'd0);
        rdreg(5'd5, 5'd25, d);
        chk("R4 reg25 read", d, 16'h0005);
        do_reset(5'd0, 1'b0);
        chk("R6 ctrl after reset, strap 0", ctrl_o, 16'h0400);
        chk("R5 isolate with addr 0", {15'b0, isolate_o}, 16'd1);
        rdreg(5'd0, 5'd0, d);
        chk("R12 read while isolated", d, 16'h0400);
        do_reset(5'd0, 1'b1);
        chk("R7 port 1 forces bit0", {11'b0, phy_addr_o}, 16'd1);
        chk("R7 port 1 no isolate at reset", ctrl_o, 16'h0000);
    endtask

    task automatic t_turnaround;
        logic [15:0] d; logic t, o;
        wr(5'd1, 5'd16, 16'hA5C3);
        frame(32, 2'b10, 5'd1, 5'd16, 16'h0, d, t, o);
        chk("R1 turnaround release then zero", {15'b0, t}, 16'd1);
        chk("R1 read data MSB first", d, 16'hA5C3);
        chk("R10 vendor reg16 r/w", d, 16'hA5C3);
        wr(5'd1, 5'd31, 16'h8001);
        rdreg(5'd1, 5'd31, d);
        chk("R10 vendor reg31 r/w", d, 16'h8001);
    endtask

    task automatic t_readonly;
        logic [15:0] d;
        rdreg(5'd1, 5'd1, d); chk("R9 reg1 default", d, 16'h7809);
        wr(5'd1, 5'd2, 16'hFFFF);
        rdreg(5'd1, 5'd2, d); chk("R9 reg2 ignores write", d, 16'h0043);
        rdreg(5'd1, 5'd4, d); chk("R9 reg4 default", d, 16'h01E1);
        rdreg(5'd1, 5'd6, d); chk("R9 reg6 default", d, 16'h0004);
        wr(5'd1, 5'd9, 16'h1234);
        rdreg(5'd1, 5'd9, d); chk("R9 reg9 reads zero", d, 16'h0000);
    endtask

    task automatic t_foreign_and_bad;
        logic [15:0] d; logic t, o;
        wr(5'd3, 5'd16, 16'h5A5A);
        frame(32, 2'b10, 5'd3, 5'd16, 16'h0, d, t, o);
        chk("R8 foreign read never drives", {15'b0, o}, 16'd0);
        rdreg(5'd1, 5'd16, d);
        chk("R8 foreign write ignored", d, 16'hA5C3);
        frame(20, 2'b01, 5'd1, 5'd16, 16'h1234, d, t, o);
        rdreg(5'd1, 5'd16, d);
        chk("R11 short preamble ignored", d, 16'hA5C3);
        frame(32, 2'b11, 5'd1, 5'd16, 16'h2468, d, t, o);
        rdreg(5'd1, 5'd16, d);
        chk("R11 opcode 11 ignored", d, 16'hA5C3);
    endtask

    task automatic t_isolate;
        logic [15:0] d;
        wr(5'd1, 5'd0, 16'h0400);
        chk("R2 ctrl written", ctrl_o, 16'h0400);
        chk("R3 isolate from ctrl bit", {15'b0, isolate_o}, 16'd1);
        wr(5'd1, 5'd17, 16'h0F0F);
        rdreg(5'd1, 5'd17, d);
        chk("R12 r/w while isolated", d, 16'h0F0F);
        wr(5'd1, 5'd0, 16'h0000);
        chk("R3 isolate clears", {15'b0, isolate_o}, 16'd0);
        wr(5'd1, 5'd25, 16'h0000);
        chk("R5 isolate from addr 0", {15'b0, isolate_o}, 16'd1);
        chk("R5 ctrl bit unchanged", ctrl_o, 16'h0000);
        rdreg(5'd0, 5'd25, d);
        chk("R4 new address answers", d, 16'h0000);
        wr(5'd0, 5'd25, 16'h0007);
        chk("R4 address rewritten", {11'b0, phy_addr_o}, 16'd7);
        chk("R5 isolate released", {15'b0, isolate_o}, 16'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        t_reset_values;
        t_turnaround;
        t_readonly;
        t_foreign_and_bad;
        t_isolate;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule